// File: doc/BRIEF.md
# Paged Outbound Address Translator

This block turns a narrow local memory-mapped request address into a 64-bit PCI Express bus address before the request goes on to the transaction layer. Every page of the local space is steered through a table of page entries held in registers. The low offset bits of the local address pass straight through. The bits just above the offset pick one table entry, and that entry supplies the upper part of the bus address.

All entries share one page size, `PAGE_BITS`, which is set at build time and may range from 12 (4 KB pages) to 32 (4 GB pages). Each entry is `UP_AW - PAGE_BITS` bits wide, where `UP_AW` is the width of the upstream address space. Bus address bits at `UP_AW` and above are always zero. `ENTRIES` must be a power of two from 2 to 512.

Requests come in on a valid/ready handshake and leave one cycle later from an output register with its own valid/ready. A register port writes and reads table entries by index. Reset is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `paged_xlat_out`

## Requirements
- R1: Bits [PAGE_BITS-1:0] of an accepted local address appear unchanged in bits [PAGE_BITS-1:0] of the translated bus address.
- R2: Local address bits [PAGE_BITS+IDX_W-1:PAGE_BITS] select a table entry, where IDX_W = log2(ENTRIES). That entry's contents appear in bus address bits [UP_AW-1:PAGE_BITS].
- R3: Local address bits above PAGE_BITS+IDX_W-1 have no effect on the translated address.
- R4: Bus address bits [63:UP_AW] are zero whenever `rsp_valid` is high.
- R5: A write with `cfg_wr` high stores `cfg_wdata` in entry `cfg_idx`. A read with `cfg_rd` high returns that entry on `cfg_rdata` in the next cycle, and `cfg_rdata` holds its value in cycles with no read.
- R6: A table write made at a clock edge before the edge at which a request is accepted is used by that request. A request accepted at the same edge as the write uses the entry's previous contents.
- R7: A request accepted at a clock edge (`req_valid` and `req_ready` both high) is presented with `rsp_valid` high after that same edge, giving one cycle of latency.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_addr` stays stable and `req_ready` is low. `req_ready` is high whenever the output is empty or `rsp_ready` is high.
- R9: Reset clears every table entry to zero and drives `rsp_valid` and `cfg_rdata` to zero.
- R10: When a read and a write address the same entry at the same edge, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Translator can take a request |
| req_addr | input | LOC_AW | Local request address |
| rsp_valid | output | 1 | Translated request present |
| rsp_ready | input | 1 | Downstream takes the translated request |
| rsp_addr | output | 64 | Translated bus address |
| cfg_wr | input | 1 | Table entry write strobe |
| cfg_rd | input | 1 | Table entry read strobe |
| cfg_idx | input | IDX_W | Entry index for read or write |
| cfg_wdata | input | UP_AW-PAGE_BITS | Entry write value |
| cfg_rdata | output | UP_AW-PAGE_BITS | Entry read value, registered |

## Verification
The hardest cases to reach from the ports are a table write landing at the very edge where a request for the same entry is accepted, and a new request arriving while the output is stalled. The bench drives the write strobe and the request in the same cycle, then repeats the request one cycle later, so both the old and the new entry contents are observed. It holds `rsp_ready` low across several cycles with a second request waiting, then releases it so that a request drains and another is accepted at the same edge. A long stretch of random traffic on both ports is compared every cycle against a behavioural model that keeps its own copy of the table.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;

  localparam int unsigned BUS_AW = 64;

  typedef logic [BUS_AW-1:0] bus_addr_t;

  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_state_e;

endpackage

// File: rtl/xlat_rst_sync.sv
`timescale 1ns/1ps
module xlat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ni = sync_q[1];

endmodule

// File: rtl/xlat_page_table.sv
`timescale 1ns/1ps
module xlat_page_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ENTRY_W = 36,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data,
  input  logic [IDX_W-1:0]   lk_idx,
  output logic [ENTRY_W-1:0] lk_data
);

  logic [ENTRIES-1:0][ENTRY_W-1:0] ent_vec;
  logic [ENTRIES-1:0]              ent_we;
  logic [ENTRY_W-1:0]              rd_d;
  logic [ENTRY_W-1:0]              rd_q;

  // Write decode: one enable per entry
  always_comb begin
    for (int i = 0; i < int'(ENTRIES); i++) begin
      ent_we[i] = wr_en && (wr_idx == IDX_W'(i));
    end
  end

  for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_ent
    logic [ENTRY_W-1:0] q;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (ent_we[g]) begin
        q <= wr_data;
      end
    end
    assign ent_vec[g] = q;
  end

  // Lookup port for translation (reads state before any same-edge write)
  assign lk_data = ent_vec[lk_idx];

  // Register read port
  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      rd_d = ent_vec[rd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

  // A completed write is what the lookup port sees on the next cycle
  assert_write_visible_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && (lk_idx == wr_idx)) |=> (!$stable(lk_idx) || (lk_data == $past(wr_data))))
    else $error("R6 write not visible to lookup");

  // Idle read port holds its last value
  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |=> $stable(rd_data))
    else $error("R5 read data moved without a read");

endmodule

// File: rtl/xlat_addr_build.sv
`timescale 1ns/1ps
module xlat_addr_build
  import xlat_pkg::*;
#(
  parameter int unsigned LOC_AW    = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned UP_AW     = 48,
  localparam int unsigned ENTRY_W  = UP_AW - PAGE_BITS,
  localparam int unsigned SEL_TOP  = PAGE_BITS + IDX_W
) (
  input  logic [LOC_AW-1:0]  loc_addr,
  output logic [IDX_W-1:0]   sel_idx,
  input  logic [ENTRY_W-1:0] sel_entry,
  output bus_addr_t          bus_addr
);

  assign sel_idx = loc_addr[PAGE_BITS +: IDX_W];

  if (LOC_AW > SEL_TOP) begin : g_hi
    logic addr_unused_hi;
    assign addr_unused_hi = ^loc_addr[LOC_AW-1:SEL_TOP];
  end

  always_comb begin
    bus_addr                    = '0;
    bus_addr[PAGE_BITS-1:0]     = loc_addr[PAGE_BITS-1:0];
    bus_addr[UP_AW-1:PAGE_BITS] = sel_entry;
  end

endmodule

// File: rtl/xlat_out_stage.sv
`timescale 1ns/1ps
module xlat_out_stage
  import xlat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      in_valid,
  output logic      in_ready,
  input  bus_addr_t in_addr,
  output logic      out_valid,
  input  logic      out_ready,
  output bus_addr_t out_addr
);

  slot_state_e st_q, st_d;
  bus_addr_t   addr_q;
  logic        load_en;

  assign in_ready = (st_q == SLOT_EMPTY) || out_ready;
  assign load_en  = in_valid && in_ready;

  always_comb begin
    st_d = st_q;
    if (load_en) begin
      st_d = SLOT_FULL;
    end else if (out_ready) begin
      st_d = SLOT_EMPTY;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SLOT_EMPTY;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_en) begin
      addr_q <= in_addr;
    end
  end

  assign out_valid = (st_q == SLOT_FULL);
  assign out_addr  = addr_q;

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)))
    else $error("R8 output changed during stall");

  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && in_ready) |=> (out_valid && (out_addr == $past(in_addr))))
    else $error("R7 accepted request not presented");

endmodule

// File: rtl/paged_xlat_out.sv
`timescale 1ns/1ps
module paged_xlat_out
  import xlat_pkg::*;
#(
  parameter int unsigned LOC_AW    = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned UP_AW     = 48,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned ENTRY_W  = UP_AW - PAGE_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LOC_AW-1:0]  req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [63:0]        rsp_addr,
  input  logic               cfg_wr,
  input  logic               cfg_rd,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [ENTRY_W-1:0] cfg_wdata,
  output logic [ENTRY_W-1:0] cfg_rdata
);

  logic               rst_ni;
  logic [IDX_W-1:0]   lk_idx;
  logic [ENTRY_W-1:0] lk_data;
  bus_addr_t          xl_addr;

  xlat_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  xlat_page_table #(
    .ENTRIES (ENTRIES),
    .ENTRY_W (ENTRY_W)
  ) i_table (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (cfg_wr),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata),
    .rd_en   (cfg_rd),
    .rd_idx  (cfg_idx),
    .rd_data (cfg_rdata),
    .lk_idx  (lk_idx),
    .lk_data (lk_data)
  );

  xlat_addr_build #(
    .LOC_AW    (LOC_AW),
    .PAGE_BITS (PAGE_BITS),
    .IDX_W     (IDX_W),
    .UP_AW     (UP_AW)
  ) i_build (
    .loc_addr  (req_addr),
    .sel_idx   (lk_idx),
    .sel_entry (lk_data),
    .bus_addr  (xl_addr)
  );

  xlat_out_stage i_out (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_addr   (xl_addr),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_addr  (rsp_addr)
  );

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready) |=> (rsp_addr[PAGE_BITS-1:0] == $past(req_addr[PAGE_BITS-1:0])))
    else $error("R1 offset bits altered");

  if (UP_AW < 64) begin : g_zero_chk
    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_ni)
      rsp_valid |-> (rsp_addr[63:UP_AW] == '0))
      else $error("R4 bits above upstream width set");
  end

  assert_ready_rule_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rsp_valid || rsp_ready) |-> req_ready)
    else $error("R8 ready low with room available");

endmodule

// File: tb/test_paged_xlat_out.sv
`timescale 1ns/1ps
module test_paged_xlat_out;

  localparam int LOC_AW = 32;
  localparam int PB     = 12;
  localparam int NENT   = 16;
  localparam int UPW    = 48;
  localparam int IW     = 4;
  localparam int EW     = UPW - PB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   req_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [63:0]   rsp_addr;
  logic          cfg_wr = 1'b0;
  logic          cfg_rd = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [EW-1:0] cfg_wdata = '0;
  logic [EW-1:0] cfg_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  paged_xlat_out #(.LOC_AW(LOC_AW), .PAGE_BITS(PB), .ENTRIES(NENT), .UP_AW(UPW)) i_paged_xlat_out (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  // Behavioural reference model
  logic [63:0] m_tbl [NENT];
  bit          m_valid;
  logic [63:0] m_addr;
  logic [63:0] m_rdata;

  function automatic logic [63:0] xlate(input logic [63:0] ent, input logic [31:0] a);
    longint unsigned pg, ofs, sel;
    pg  = 64'd1 << PB;
    ofs = 64'(a) % pg;
    sel = (64'(a) / pg) % NENT;
    return (m_tbl[sel] * pg + ofs) & ((64'd1 << UPW) - 1) | (ent & 64'd0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) m_tbl[i] = '0;
      m_valid = 0;
      m_addr  = '0;
      m_rdata = '0;
    end else begin
      bit acc;
      acc = req_valid && (!m_valid || rsp_ready);
      if (cfg_rd) m_rdata = m_tbl[cfg_idx];
      if (acc) begin
        m_valid = 1;
        m_addr  = xlate(64'd0, req_addr);
      end else if (rsp_ready) begin
        m_valid = 0;
      end
      if (cfg_wr) m_tbl[cfg_idx] = 64'(cfg_wdata);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, sampled 2 ns after the rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      #2;
      chk(rsp_valid == m_valid, "R7 rsp_valid", 64'(rsp_valid), 64'(m_valid));
      if (m_valid) chk(rsp_addr == m_addr, "R2 rsp_addr", rsp_addr, m_addr);
      chk(64'(cfg_rdata) == m_rdata, "R5 cfg_rdata", 64'(cfg_rdata), m_rdata);
      chk(req_ready == (!m_valid || rsp_ready), "R8 req_ready",
          64'(req_ready), 64'(!m_valid || rsp_ready));
    end
  end

  task automatic idle();
    req_valid = 0; cfg_wr = 0; cfg_rd = 0;
  endtask

  task automatic wr_ent(input int idx, input logic [EW-1:0] d);
    @(negedge clk);
    idle(); cfg_wr = 1; cfg_idx = IW'(idx); cfg_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic send(input logic [31:0] a, input logic [63:0] exp, input string req);
    @(negedge clk);
    idle(); rsp_ready = 1; req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && rsp_addr == exp, req, rsp_addr, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    fails++;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(!rsp_valid, "R9 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(cfg_rdata == '0, "R9 cfg_rdata after reset", 64'(cfg_rdata), 64'd0);
    send(32'h0000_5123, 64'h0000_0000_0000_0123, "R9 entry zero after reset");

    // R1 R2 R3 directed
    wr_ent(3, 36'h0_ABCD_1234);
    send(32'hF000_3ABC, 64'h0000_0ABC_D123_4ABC, "R2 entry 3 selected");
    send(32'h0000_3ABC, 64'h0000_0ABC_D123_4ABC, "R3 high bits ignored");
    send(32'h1234_3FFF, 64'h0000_0ABC_D123_4FFF, "R1 offset all ones");
    wr_ent(15, 36'hF_FFFF_FFFF);
    send(32'hFFFF_F000, 64'h0000_FFFF_FFFF_F000, "R4 top entry all ones");

    // R5 readback
    @(negedge clk); idle(); cfg_rd = 1; cfg_idx = 4'd3;
    @(negedge clk); idle();
    chk(cfg_rdata == 36'h0_ABCD_1234, "R5 readback", 64'(cfg_rdata), 64'h0ABCD1234);
    repeat (2) @(negedge clk);
    chk(cfg_rdata == 36'h0_ABCD_1234, "R5 rdata held", 64'(cfg_rdata), 64'h0ABCD1234);

    // R6 same-edge write uses old contents, next request uses new
    @(negedge clk);
    idle(); rsp_ready = 1; cfg_wr = 1; cfg_idx = 4'd5; cfg_wdata = 36'h0_0000_0777;
    req_valid = 1; req_addr = 32'h0000_5010;
    @(negedge clk); idle();
    chk(rsp_valid && rsp_addr == 64'h10, "R6 same edge old entry", rsp_addr, 64'h10);
    send(32'h0000_5010, 64'h0000_0000_0077_7010, "R6 new entry visible");

    // R10 read and write same entry at one edge
    @(negedge clk);
    idle(); cfg_rd = 1; cfg_wr = 1; cfg_idx = 4'd5; cfg_wdata = 36'h0_0000_0999;
    @(negedge clk); idle();
    chk(cfg_rdata == 36'h777, "R10 read returns old", 64'(cfg_rdata), 64'h777);

    // R8 stall
    @(negedge clk);
    idle(); rsp_ready = 0; req_valid = 1; req_addr = 32'h0000_3001;
    @(negedge clk);
    req_addr = 32'h0000_5002;
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid && rsp_addr == 64'h0000_0ABC_D123_4001, "R8 held during stall",
          rsp_addr, 64'h0000_0ABC_D123_4001);
      chk(!req_ready, "R8 ready low in stall", 64'(req_ready), 64'd0);
    end
    rsp_ready = 1;
    @(negedge clk);
    idle();
    chk(rsp_valid && rsp_addr == 64'h0000_0000_0099_9002, "R8 drain and accept",
        rsp_addr, 64'h0000_0000_0099_9002);

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      req_valid = ($urandom % 3) != 0;
      req_addr  = $urandom;
      rsp_ready = ($urandom % 4) != 0;
      cfg_wr    = ($urandom % 5) == 0;
      cfg_rd    = ($urandom % 4) == 0;
      cfg_idx   = IW'($urandom);
      cfg_wdata = {4'($urandom), 32'($urandom)};
    end
    @(negedge clk); idle(); rsp_ready = 1;
    repeat (3) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule